// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card bus clock from the core clock. It divides by a programmable ratio. An 11-bit divider register holds the wanted ratio minus two, so a stored value `v` gives a card clock period of `v + 2` core cycles. Zero is therefore the fastest setting (half the core rate), and the all-ones value is the slowest. The clock is never stopped.

Two divisor widths apply. During card identification the full register value sets the ratio. Once the transfer controller signals data mode, only the three least significant bits of the stored value take part. A slow-card configuration input cancels that reduction, so the full value is used in every mode.

A new register value, or a change of mode, is picked up only when the current card clock period ends. No high or low phase is ever cut short or stretched. The card clock comes from a register. The block also gives one-cycle strobes, aligned with its rising and falling edges, that the command and data logic can use as clock enables.

Top module: `sdclk_div`

## Requirements
- R1: During reset the card clock and both strobes are low, and the divider register takes the value 507. After reset, in identification mode, each period is therefore 509 core cycles long.
- R2: Let the effective divisor value be `e`. Each card clock period is then `N = e + 2` core cycles. The period begins with a high phase of `floor(N/2)` cycles, followed by a low phase of `ceil(N/2)` cycles. When `N` is odd, the high phase is one cycle shorter than the low phase.
- R3: A value of 0 gives a period of 2 core cycles: one cycle high and one cycle low.
- R4: The maximum value 0x7ff gives a period of 2049 core cycles. No setting stops the clock, and no phase lasts longer than 1025 core cycles.
- R5: When `data_mode` is 1 and `slow_card` is 0, the effective value is bits [2:0] of the register, so `N = (v & 7) + 2`.
- R6: When `slow_card` is 1, the full 11-bit value is used whatever the level of `data_mode`.
- R7: When `data_mode` is 0, the full 11-bit value is used.
- R8: A register write, or a change of `data_mode` or `slow_card`, does not change the period already in progress. It takes effect from the next rising edge of the card clock.
- R9: `rise_stb` is high for exactly the one core cycle in which `card_clk` has just gone from 0 to 1, and `fall_stb` is high for exactly the one cycle in which it has just gone from 1 to 0. Each period therefore holds exactly one of each, and the two strobes are never high together.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divider register |
| div_wdata | input | 11 | New divider value (the ratio minus two) |
| slow_card | input | 1 | 1 = always use the full divider value |
| data_mode | input | 1 | 1 = the transfer controller is in data mode |
| card_clk | output | 1 | Card clock, driven from a register |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle of `card_clk` |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle of `card_clk` |

## Verification
On every cycle, the bound checker confirms three things. The strobes mark the card clock's transitions exactly and never coincide. Within each period, the low phase equals the high phase or exceeds it by one cycle. No phase runs past the longest one the widest divisor allows. Only the bench's scenarios can show the following behaviours:
- the exact period lengths for each stored value;
- the three-bit reduction in data mode, and its override by the slow-card input;
- the reset divisor;
- the rule that a write or a mode change made inside a period leaves that period's length untouched.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Which part of the stored value sets the ratio
    typedef enum logic {
        SEL_FULL   = 1'b0,
        SEL_NARROW = 1'b1
    } div_sel_e;

    // Narrow width applies only in data mode without the slow-card override
    function automatic div_sel_e pick_sel(input logic slow, input logic dmode);
        return (dmode && !slow) ? SEL_NARROW : SEL_FULL;
    endfunction

endpackage

// File: rtl/sdclk_divreg.sv
module sdclk_divreg #(
    parameter int unsigned DIV_W     = 11,
    parameter int unsigned NARROW_W  = 3,
    parameter int unsigned RESET_DIV = 507
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic [DIV_W-1:0] eff_div
);
    import sdclk_pkg::*;

    localparam int unsigned PAD_W = DIV_W - NARROW_W;

    typedef struct packed {
        logic [DIV_W-1:0] val;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.val = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.val <= DIV_W'(RESET_DIV);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (pick_sel(slow_card, data_mode) == SEL_NARROW) begin
            eff_div = {{PAD_W{1'b0}}, r_q.val[NARROW_W-1:0]};
        end else begin
            eff_div = r_q.val;
        end
    end

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
    parameter int unsigned DIV_W     = 11,
    parameter int unsigned RESET_DIV = 507
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] eff_div,
    output logic             card_clk,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int unsigned CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic             clk;
        logic             rise;
        logic             fall;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        last_idx = {1'b0, s_q.act} + CNT_W'(1);
        hi_len   = ({1'b0, s_q.act} + CNT_W'(2)) >> 1;
        cnt_inc  = s_q.cnt + CNT_W'(1);
        s_d      = s_q;
        if (s_q.cnt == last_idx) begin
            s_d.cnt  = '0;
            s_d.act  = eff_div;
            s_d.clk  = 1'b1;
            s_d.rise = 1'b1;
            s_d.fall = 1'b0;
        end else begin
            s_d.cnt  = cnt_inc;
            s_d.clk  = (cnt_inc < hi_len);
            s_d.rise = 1'b0;
            s_d.fall = s_q.clk && !(cnt_inc < hi_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_W'(RESET_DIV + 1);
            s_q.act  <= DIV_W'(RESET_DIV);
            s_q.clk  <= 1'b0;
            s_q.rise <= 1'b0;
            s_q.fall <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign card_clk = s_q.clk;
    assign rise_stb = s_q.rise;
    assign fall_stb = s_q.fall;

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
    parameter int unsigned DIV_W     = 11,
    parameter int unsigned NARROW_W  = 3,
    parameter int unsigned RESET_DIV = 507
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic             card_clk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] eff_div;

    sdclk_divreg #(
        .DIV_W    (DIV_W),
        .NARROW_W (NARROW_W),
        .RESET_DIV(RESET_DIV)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (div_wr),
        .wdata    (div_wdata),
        .slow_card(slow_card),
        .data_mode(data_mode),
        .eff_div  (eff_div)
    );

    sdclk_phase #(
        .DIV_W    (DIV_W),
        .RESET_DIV(RESET_DIV)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .eff_div (eff_div),
        .card_clk(card_clk),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb)
    );

endmodule

// File: rtl/sdclk_div_chk.sv
module sdclk_div_chk #(
    parameter int unsigned DIV_W = 11
) (
    input logic clk,
    input logic rst_n,
    input logic card_clk,
    input logic rise_stb,
    input logic fall_stb
);
    localparam int unsigned RUN_W   = DIV_W + 2;
    localparam int unsigned MAX_LOW = ((1 << DIV_W) + 2) / 2;

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] hi_run_q;
    logic             lvl_q;
    logic             seen_fall_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= '0;
            hi_run_q    <= '0;
            lvl_q       <= 1'b0;
            seen_fall_q <= 1'b0;
        end else begin
            lvl_q <= card_clk;
            if (card_clk != lvl_q) begin
                run_q <= RUN_W'(1);
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
            if (fall_stb) begin
                hi_run_q    <= run_q;
                seen_fall_q <= 1'b1;
            end
        end
    end

    // R9
    rise_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb == (card_clk && !lvl_q));

    // R9
    fall_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb == (!card_clk && lvl_q));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R2
    low_vs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && seen_fall_q) |-> (run_q == hi_run_q || run_q == hi_run_q + RUN_W'(1)));

    // R4
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_LOW));

endmodule

bind sdclk_div sdclk_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .card_clk(card_clk),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
);

// File: tb/sdclk_div_test.sv
`timescale 1ns/1ps
module sdclk_div_test;
    localparam int DIV_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             slow_card = 1'b0;
    logic             data_mode = 1'b0;
    logic             card_clk;
    logic             rise_stb;
    logic             fall_stb;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdclk_div uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_wdata(div_wdata),
        .slow_card(slow_card),
        .data_mode(data_mode),
        .card_clk (card_clk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (!rise_stb) @(negedge clk);
    endtask

    // Called at the negedge where rise_stb was seen; stops at the next rise
    task automatic count_period(output int n, output int hi, output int falls);
        n = 1; hi = 1; falls = 0;
        forever begin
            @(negedge clk);
            div_wr = 1'b0;
            if (rise_stb) break;
            n++;
            if (card_clk) hi++;
            if (fall_stb) falls++;
        end
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = DIV_W'(v);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    // Second full period after the change is the settled one
    task automatic measure(input string req, input int exp_n);
        int n, hi, f;
        wait_rise();
        count_period(n, hi, f);
        count_period(n, hi, f);
        check(req, n, exp_n);
        check(req, hi, exp_n / 2);
        check("R9", f, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int n, hi, f;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", int'(card_clk), 0);
        check("R1", int'(rise_stb), 0);
        check("R1", int'(fall_stb), 0);
        rst_n = 1'b1;
        measure("R1", 509);

        // R7 and R2: identification mode sweep
        for (int v = 0; v <= 24; v++) begin
            write_div(v);
            measure(v == 0 ? "R3" : "R7", v + 2);
        end
        write_div(623);
        measure("R2", 625);
        write_div(2047);
        measure("R4", 2049);

        // R5: data mode, narrow divisor
        data_mode = 1'b1;
        for (int v = 0; v <= 40; v += 3) begin
            write_div(v);
            measure("R5", (v & 7) + 2);
        end
        write_div(2047);
        measure("R5", 9);

        // R6: slow card overrides data mode
        slow_card = 1'b1;
        for (int v = 8; v <= 20; v += 4) begin
            write_div(v);
            measure("R6", v + 2);
        end
        slow_card = 1'b0;
        data_mode = 1'b0;

        // R8: write inside a period does not alter it
        write_div(100);
        measure("R8", 102);
        wait_rise();
        div_wr = 1'b1;
        div_wdata = DIV_W'(0);
        count_period(n, hi, f);
        check("R8", n, 102);
        count_period(n, hi, f);
        check("R8", n, 2);

        // R8: mode change inside a period does not alter it
        write_div(100);
        measure("R8", 102);
        wait_rise();
        data_mode = 1'b1;
        count_period(n, hi, f);
        check("R8", n, 102);
        count_period(n, hi, f);
        check("R8", n, 6);
        check("R8", hi, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule